// File: doc/BRIEF.md
# Fixed-Point Second-Order Loop Filter

This block is the loop filter of an all-digital phase-locked loop. It takes signed phase-error samples from the detector and produces a signed control word for the numerically controlled oscillator. The transfer function is the zero-order-hold discretisation, at a 10 ns sample period, of a series resistor-capacitor branch in parallel with a shunt capacitor. It has one pole exactly on the unit circle (an integrator), a second pole near 0.9696, and a zero near 0.9947.

The filter is built in direct form I. Every coefficient is held in fixed point with 13 fraction bits. The two feedback coefficients are a1 = 16135 and a2 = 7943. Because a1 − a2 equals 2^13 exactly, the integrator pole sits at z = 1 with no quantisation error. The two feed-forward coefficients are b1 = 4646 and b2 = 4622, which is the analogue gain of about 580.8 with the input scaled by 2^-10.

Each product is 32 bits wide and the four products are summed in a 32-bit accumulator. The sum is rounded to the nearest integer (a tie rounds upward) and clamped to 16 bits. The clamped value is both the output and the value stored as output history. The filter is strictly proper, so a new sample first affects the output one sample later.

Top module: `loop_filter`

## Requirements
- R1: While rst_n is low, and on the first rising clock edge after it goes low, out_valid and out_word become 0 and all four history registers are cleared. The next accepted sample after reset therefore produces out_word = 0.
- R2: out_valid is high in the cycle after each cycle in which in_valid is high, and it is low in every other cycle.
- R3: For each accepted sample n, the filter first forms acc = 16135·y[n−1] − 7943·y[n−2] + 4646·x[n−1] − 4622·x[n−2] as a two's-complement integer. The output is then y[n] = floor((acc + 4096) / 8192), clamped as in R5. This value appears on out_word one cycle after the sample is accepted.
- R4: The sample accepted in cycle n has no effect on y[n]. It first enters the output at y[n+1].
- R5: A rounded value above 32767 is output as 32767, and a rounded value below −32768 is output as −32768. The clamped value is what is kept as y[n−1] for later samples.
- R6: While in_valid is low, in_sample is ignored. out_word holds its value and the history does not move, so the next accepted sample gives the same result as it would with no idle cycles in between.
- R7: A single nonzero input pulse followed by zero inputs leaves a lasting nonzero output, because of the integrator pole at z = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks in_sample as a new error sample |
| in_sample | input | 16 | Signed phase-error sample |
| out_valid | output | 1 | High for one cycle when out_word holds a new result |
| out_word | output | 16 | Signed, saturated frequency-control word |

## Verification
The assertions assume that in_valid is a clean level sampled at the rising edge. They also assume the input is a full-range 16-bit two's-complement value, so that the 32-bit accumulator can never wrap. With all coefficient magnitudes summed, the worst case is about 1.09·10^9. The saturation properties compare the accumulator against fixed thresholds derived from the rounding rule, rather than against the requantiser's own expression.

The stimulus stays inside these limits and includes the extreme codes 32767 and −32768. It drives inputs long enough to push the integrator into both clamps. It also inserts idle cycles that carry junk sample values, to show that nothing leaks in while in_valid is low.

// File: rtl/lf_pkg.sv
// Shared widths and types for the loop filter.
// Assumes that products and the accumulator share one width, at least twice the sample width.
package lf_pkg;
    localparam int SAMPLE_W  = 16;
    localparam int ACC_W     = 32;
    localparam int COEF_FRAC = 13;
    localparam int NUM_TERMS = 4;

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic signed [ACC_W-1:0]    acc_t;
endpackage

// File: rtl/lf_tap_pair.sv
// Two-deep delay line with an enable.
// Assumes a synchronous active-low reset that clears both taps to zero.
module lf_tap_pair #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] tap1,
    output logic [W-1:0] tap2
);
    // Shift a new value in when enabled; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap1 <= '0;
            tap2 <= '0;
        end else if (en) begin
            tap1 <= d;
            tap2 <= tap1;
        end
    end
endmodule

// File: rtl/lf_mac.sv
// Sum of N signed products, each of sample width times coefficient width.
// Assumes ACC_W >= 2*W and that the coefficients keep the sum inside ACC_W bits.
module lf_mac #(
    parameter int W     = 16,
    parameter int ACC_W = 32,
    parameter int N     = 4
) (
    input  logic [N*W-1:0]           samples,
    input  logic [N*W-1:0]           coefs,
    output logic signed [ACC_W-1:0]  acc
);
    localparam int PROD_W = 2 * W;

    logic signed [PROD_W-1:0] prod [N];

    for (genvar g = 0; g < N; g++) begin : g_prod
        assign prod[g] = $signed(samples[g*W +: W]) * $signed(coefs[g*W +: W]);
    end

    // Add the sign-extended products together.
    always_comb begin
        acc = '0;
        for (int i = 0; i < N; i++) begin
            acc = acc + ACC_W'(prod[i]);
        end
    end
endmodule

// File: rtl/lf_requant.sv
// Rounds a fixed-point accumulator to the nearest integer (a tie rounds up),
// then clamps it to OUT_W signed bits.
// Assumes FRAC >= 1.
module lf_requant #(
    parameter int ACC_W  = 32,
    parameter int OUT_W  = 16,
    parameter int FRAC   = 13
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] y
);
    localparam int HALF = 1 << (FRAC - 1);
    localparam logic signed [ACC_W:0] MAX_V = (ACC_W+1)'((2 ** (OUT_W - 1)) - 1);
    localparam logic signed [ACC_W:0] MIN_V = -MAX_V - 1;

    logic signed [ACC_W:0] biased;
    logic signed [ACC_W:0] shifted;

    assign biased  = {acc[ACC_W-1], acc} + (ACC_W+1)'(HALF);
    assign shifted = biased >>> FRAC;

    // Clamp the rounded value to the output range.
    always_comb begin
        if (shifted > MAX_V)      y = MAX_V[OUT_W-1:0];
        else if (shifted < MIN_V) y = MIN_V[OUT_W-1:0];
        else                      y = shifted[OUT_W-1:0];
    end
endmodule

// File: rtl/loop_filter.sv
// Direct-form-I second-order loop filter, with an integrator pole exactly at z = 1.
// Assumes the coefficients are constants with COEF_FRAC fraction bits, and that
// FB_A2 + 2^COEF_FRAC fits in the sample width.
// One result is produced per accepted sample, one cycle later.
module loop_filter
    import lf_pkg::*;
#(
    parameter int W      = SAMPLE_W,
    parameter int AW     = ACC_W,
    parameter int FRAC   = COEF_FRAC,
    parameter int FB_A2  = 7943,
    parameter int FF_B1  = 4646,
    parameter int FF_B2  = 4622
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_sample,
    output logic         out_valid,
    output logic [W-1:0] out_word
);
    localparam int N     = NUM_TERMS;
    localparam int FB_A1 = (1 << FRAC) + FB_A2;
    // Term order: y[n-1], y[n-2], x[n-1], x[n-2]
    localparam logic [N*W-1:0] COEFS = {W'(-FF_B2), W'(FF_B1), W'(-FB_A2), W'(FB_A1)};

    logic [W-1:0]           y1, y2, x1, x2;
    logic signed [W-1:0]    y_next;
    logic signed [AW-1:0]   acc_sum;

    lf_tap_pair #(.W(W)) u_xhist (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .d(in_sample), .tap1(x1), .tap2(x2)
    );

    lf_tap_pair #(.W(W)) u_yhist (
        .clk(clk), .rst_n(rst_n), .en(in_valid), .d(y_next), .tap1(y1), .tap2(y2)
    );

    lf_mac #(.W(W), .ACC_W(AW), .N(N)) u_mac (
        .samples({x2, x1, y2, y1}), .coefs(COEFS), .acc(acc_sum)
    );

    lf_requant #(.ACC_W(AW), .OUT_W(W), .FRAC(FRAC)) u_rq (
        .acc(acc_sum), .y(y_next)
    );

    // Register the result and its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_word <= y_next;
        end
    end
endmodule

// File: rtl/lf_checker.sv
// Temporal properties of loop_filter. Bound to every instance of it.
module lf_checker #(
    parameter int AW    = 32,
    parameter int W     = 16,
    parameter int FRAC  = 13
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 out_valid,
    input logic [W-1:0]         out_word,
    input logic signed [AW-1:0] acc_sum
);
    localparam longint SCALE = longint'(1) << FRAC;
    localparam longint TOP   = longint'(1) << (W - 1);
    localparam longint HI_T  = TOP * SCALE - SCALE / 2;
    localparam longint LO_T  = -TOP * SCALE - SCALE / 2;
    localparam logic [W-1:0] W_MAX = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] W_MIN = {1'b1, {(W-1){1'b0}}};

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R2
    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(out_word)); // R6
    AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && longint'(acc_sum) >= HI_T) |=> out_word == W_MAX); // R5
    AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n) (in_valid && longint'(acc_sum) < LO_T) |=> out_word == W_MIN); // R5
endmodule

bind loop_filter lf_checker #(.AW(AW), .W(W), .FRAC(FRAC)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_valid(out_valid),
    .out_word(out_word), .acc_sum(acc_sum)
);

// File: tb/loop_filter_test.sv
module loop_filter_test;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;
    localparam bit TV_V [NVEC] = '{1,1,0,1,1,1,0,0,1,1,1,0,1,1,1,1};
    localparam int TV_X [NVEC] = '{1000, -2000, 12345, 5000, 0, 0, -777, 31000,
                                   -12000, 300, 32767, -5, -32768, 7, 0, -1};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_sample = '0;
    logic        out_valid;
    logic [15:0] out_word;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    longint m_x1, m_x2, m_y1, m_y2;
    int     exp_word = 0;

    loop_filter uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_word(out_word)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model_clear();
        m_x1 = 0; m_x2 = 0; m_y1 = 0; m_y2 = 0; exp_word = 0;
    endtask

    // Apply one cycle of input, then compare the outputs with the model at the next falling edge.
    task automatic step(input bit v, input int x, input string req);
        longint acc, r;
        in_valid  = v;
        in_sample = 16'(x);
        if (v) begin
            acc = 16135 * m_y1 - 7943 * m_y2 + 4646 * m_x1 - 4622 * m_x2;
            r = (acc + 4096) >>> 13;
            if (r > 32767) r = 32767;
            if (r < -32768) r = -32768;
            m_x2 = m_x1; m_x1 = longint'(x);
            m_y2 = m_y1; m_y1 = r;
            exp_word = int'(r);
        end
        @(negedge clk);
        check(out_valid == v, {req, " valid"}, int'(out_valid), int'(v));
        check($signed(out_word) == exp_word, req, int'($signed(out_word)), exp_word);
    endtask

    task automatic do_reset();
        in_valid = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
        check(out_word == 16'd0, "R1 reset word", int'($signed(out_word)), 0);
        rst_n = 1'b1;
        model_clear();
    endtask

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 initial valid", int'(out_valid), 0);
        check(out_word == 16'd0, "R1 initial word", int'($signed(out_word)), 0);
        rst_n = 1'b1;

        // Vector table: mixed samples and idle cycles (R2, R3, R6)
        for (int i = 0; i < NVEC; i++) step(TV_V[i], TV_X[i], "R3 table");

        // Strict properness and a known value (R4, R3)
        do_reset();
        step(1'b1, 32767, "R4 first sample after reset");
        step(1'b1, 32767, "R3 step");
        check($signed(out_word) == 18583, "R3 hand value", int'($signed(out_word)), 18583);

        // Positive clamp (R5)
        for (int i = 0; i < 30; i++) step(1'b1, 32767, "R5 ramp up");
        check($signed(out_word) == 32767, "R5 clamp high", int'($signed(out_word)), 32767);

        // Idle cycles with junk input (R6)
        for (int i = 0; i < 5; i++) step(1'b0, -20000 + i * 9000, "R6 idle hold");
        step(1'b1, 100, "R6 resume");

        // Negative clamp (R5)
        for (int i = 0; i < 60; i++) step(1'b1, -32768, "R5 ramp down");
        check($signed(out_word) == -32768, "R5 clamp low", int'($signed(out_word)), -32768);

        // Mid-run reset (R1)
        do_reset();
        step(1'b1, -32768, "R1 cleared history");

        // Impulse response through the integrator (R7)
        do_reset();
        step(1'b1, 8192, "R7 impulse");
        for (int i = 0; i < 60; i++) step(1'b1, 0, "R7 tail");
        check($signed(out_word) > 0, "R7 lasting output", int'($signed(out_word)), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule